// File: doc/BRIEF.md
# Unframed Serial Stream Ping-Pong Capturer

This block takes in an endless serial bit stream made of only a data line and a bit clock. The stream has no chip select, no start marker and no pauses. The serial clock and data are brought into the system clock domain, and every rising serial-clock edge counts as one bit. A single free-running bit counter supplies the only framing. It cuts the stream into chunks of `CHUNK_BITS` bits and sends alternate chunks into two halves of a double buffer, called bank 0 and bank 1.

While one bank fills, the consumer reads the other bank through a registered parallel port, then acknowledges it. The counter has two compare points, at the end of each bank's chunk. At the second one it wraps to zero, so the cycle of two banks repeats for ever and no bit is dropped between chunks. Each finished chunk raises a one-cycle ready pulse and a level interrupt. If the consumer is too slow, a sticky overrun flag records it.

Top module: `stream_pingpong_capture`

## Requirements
- R1: After synchronous reset, `bank_full` is 00, `overrun`, `irq` and `chunk_rdy` are 0, and `fill_bank` is 0 (bank 0 fills first).
- R2: One bit is taken on each rising edge of `ser_clk`, MSB first. Each `WORD_W`-bit word of a chunk is stored at read index i, where i is its position in the chunk (0 is the first word received).
- R3: A chunk is exactly `CHUNK_BITS` consecutive bits (`CHUNK_BITS/WORD_W` words). Consecutive chunks follow each other with no gap, and no bit is lost at a chunk boundary.
- R4: Chunks fill bank 0, bank 1, bank 0, and so on. `fill_bank` shows the bank being filled. The bit counter wraps after 2·`CHUNK_BITS` bits.
- R5: When a chunk completes, `chunk_rdy` pulses for one cycle with `chunk_bank` naming the bank, and `bank_full[chunk_bank]` becomes 1.
- R6: `irq` is 1 whenever any `bank_full` bit is 1, and 0 when both are 0.
- R7: Asserting `ack` for one cycle clears `bank_full[ack_bank]`.
- R8: If the first word of a new chunk is written into a bank whose `bank_full` bit is still 1, `overrun` becomes 1 and the bank's old contents are overwritten. `overrun` is cleared only by reset.
- R9: A reset in the middle of a word discards the partial bits. The next bits start word 0 of a chunk in bank 0.
- R10: `rd_data` shows the word selected by `rd_bank`/`rd_idx` one clock after they are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial bit clock; bit taken on rising edge; rate below clk/4 |
| ser_dat | input | 1 | Serial data line |
| rd_bank | input | 1 | Bank to read |
| rd_idx | input | IDX_W | Word index within the bank |
| rd_data | output | WORD_W | Registered read data |
| ack | input | 1 | One-cycle acknowledge of a bank |
| ack_bank | input | 1 | Bank being acknowledged |
| chunk_rdy | output | 1 | One-cycle pulse: a chunk completed |
| chunk_bank | output | 1 | Bank of the chunk just completed |
| irq | output | 1 | Level interrupt: a bank awaits reading |
| bank_full | output | 2 | Per-bank full flags |
| overrun | output | 1 | Sticky: a full bank was refilled |
| fill_bank | output | 1 | Bank currently being filled |

## Verification
A serial bit reaches the bit strobe about four system clocks after its `ser_clk` rising edge. The flags and buffer write follow one clock later, and a read returns one clock after the address is set. The serial stream is therefore not sampled at a fixed cycle. Instead, the bench watches `chunk_rdy` on falling clock edges and treats the cycle of that pulse as the point where `chunk_bank`, `bank_full` and `irq` must be valid. Reads set the address on a falling edge and sample `rd_data` on the very next falling edge, which holds the design to its one-cycle read latency. Flag changes after an acknowledge are sampled two falling edges later.

// File: rtl/spp_pkg.sv
package spp_pkg;
  typedef enum logic {BANK_A = 1'b0, BANK_B = 1'b1} bank_e;
endpackage

// File: rtl/spp_bit_sync.sv
module spp_bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ser_clk,
  input  logic ser_dat,
  output logic bit_stb,
  output logic bit_val
);
  logic [STAGES-1:0] ck_sh, dt_sh;
  logic              ck_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      ck_sh   <= '0;
      dt_sh   <= '0;
      ck_last <= 1'b0;
      bit_stb <= 1'b0;
      bit_val <= 1'b0;
    end else begin
      ck_sh   <= {ck_sh[STAGES-2:0], ser_clk};
      dt_sh   <= {dt_sh[STAGES-2:0], ser_dat};
      ck_last <= ck_sh[STAGES-1];
      bit_stb <= ck_sh[STAGES-1] & ~ck_last;
      bit_val <= dt_sh[STAGES-1];
    end
  end

  // one rising edge cannot produce strobes on adjacent cycles (R2)
  assert_single_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    bit_stb |=> !bit_stb);
endmodule

// File: rtl/spp_framer.sv
module spp_framer
  import spp_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int CHUNK_BITS = 64,
  parameter int IDX_W      = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_stb,
  input  logic              bit_val,
  output logic              we,
  output logic [IDX_W:0]    waddr,
  output logic [WORD_W-1:0] wdata,
  output logic              wr_first,
  output logic              chunk_done,
  output bank_e             done_bank,
  output logic              fill_bank
);
  localparam int CNT_W = $clog2(2 * CHUNK_BITS);
  localparam int BIT_W = $clog2(WORD_W);

  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] shreg;
  logic [IDX_W-1:0]  widx;
  logic              last_bit, chunk_end;

  always_comb begin
    widx      = IDX_W'(cnt[CNT_W-2:0] >> BIT_W);
    last_bit  = (cnt[BIT_W-1:0] == '1);
    chunk_end = (cnt[CNT_W-2:0] == '1);
  end

  assign fill_bank = cnt[CNT_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      shreg      <= '0;
      we         <= 1'b0;
      waddr      <= '0;
      wdata      <= '0;
      wr_first   <= 1'b0;
      chunk_done <= 1'b0;
      done_bank  <= BANK_A;
    end else begin
      we         <= 1'b0;
      chunk_done <= 1'b0;
      if (bit_stb) begin
        shreg <= {shreg[WORD_W-2:0], bit_val};
        cnt   <= cnt + 1'b1;
        if (last_bit) begin
          we       <= 1'b1;
          wdata    <= {shreg[WORD_W-2:0], bit_val};
          waddr    <= {cnt[CNT_W-1], widx};
          wr_first <= (widx == '0);
        end
        if (chunk_end) begin
          chunk_done <= 1'b1;
          done_bank  <= bank_e'(cnt[CNT_W-1]);
        end
      end
    end
  end

  // a completed chunk hands filling to the other bank (R4)
  assert_bank_swap_R4: assert property (@(posedge clk) disable iff (rst)
    chunk_done |-> (fill_bank != done_bank));
  // words are written only in reaction to a serial bit (R2)
  assert_write_after_bit_R2: assert property (@(posedge clk) disable iff (rst)
    we |-> $past(bit_stb));
endmodule

// File: rtl/spp_dual_buf.sv
module spp_dual_buf #(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);
  localparam int DEPTH = 2 ** ADDR_W;
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/stream_pingpong_capture.sv
module stream_pingpong_capture
  import spp_pkg::*;
#(
  parameter  int WORD_W     = 16,
  parameter  int CHUNK_BITS = 64,
  parameter  int SYNC_STAGES = 2,
  localparam int WORDS      = CHUNK_BITS / WORD_W,
  localparam int IDX_W      = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              rd_bank,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_data,
  input  logic              ack,
  input  logic              ack_bank,
  output logic              chunk_rdy,
  output logic              chunk_bank,
  output logic              irq,
  output logic [1:0]        bank_full,
  output logic              overrun,
  output logic              fill_bank
);
  logic              bit_stb, bit_val;
  logic              we, wr_first, chunk_done;
  logic [IDX_W:0]    waddr;
  logic [WORD_W-1:0] wdata;
  bank_e             done_bank;
  logic [1:0]        full_nxt;

  spp_bit_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .bit_stb(bit_stb), .bit_val(bit_val));

  spp_framer #(.WORD_W(WORD_W), .CHUNK_BITS(CHUNK_BITS), .IDX_W(IDX_W)) u_framer (
    .clk(clk), .rst(rst), .bit_stb(bit_stb), .bit_val(bit_val),
    .we(we), .waddr(waddr), .wdata(wdata), .wr_first(wr_first),
    .chunk_done(chunk_done), .done_bank(done_bank), .fill_bank(fill_bank));

  spp_dual_buf #(.WORD_W(WORD_W), .ADDR_W(IDX_W + 1)) u_buf (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr({rd_bank, rd_idx}), .rdata(rd_data));

  always_comb begin
    full_nxt = bank_full;
    if (ack) full_nxt[ack_bank] = 1'b0;
    if (chunk_done) full_nxt[done_bank] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_full  <= '0;
      overrun    <= 1'b0;
      chunk_rdy  <= 1'b0;
      chunk_bank <= 1'b0;
      irq        <= 1'b0;
    end else begin
      bank_full  <= full_nxt;
      irq        <= |full_nxt;
      chunk_rdy  <= chunk_done;
      if (chunk_done) chunk_bank <= done_bank;
      if (we && wr_first && bank_full[waddr[IDX_W]]) overrun <= 1'b1;
    end
  end

  // overrun never drops without reset (R8)
  assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    $past(overrun) |-> overrun);
  // a ready pulse always comes with its bank marked full (R5)
  assert_pulse_marks_full_R5: assert property (@(posedge clk) disable iff (rst)
    chunk_rdy |-> bank_full[chunk_bank]);
  // a full bank keeps the interrupt raised (R6)
  assert_irq_when_full_R6: assert property (@(posedge clk) disable iff (rst)
    (bank_full != 2'b00) |-> irq);
endmodule

// File: tb/stream_pingpong_capture_test.sv
module stream_pingpong_capture_test;
  localparam int W = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic ser_clk = 1'b0, ser_dat = 1'b0;
  logic rd_bank = 1'b0, ack = 1'b0, ack_bank = 1'b0;
  logic [1:0] rd_idx = '0;
  logic [W-1:0] rd_data;
  logic chunk_rdy, chunk_bank, irq, overrun, fill_bank;
  logic [1:0] bank_full;

  int nchk = 0, nfail = 0;

  localparam logic [W-1:0] VEC [16] = '{
    16'hA5C3, 16'h0000, 16'hFFFF, 16'h8001,
    16'h1234, 16'hFEDC, 16'h5555, 16'hAAAA,
    16'h0F0F, 16'hF0F0, 16'h7FFE, 16'h0001,
    16'h8000, 16'hC0DE, 16'h3C3C, 16'h9669};

  stream_pingpong_capture #(.WORD_W(W), .CHUNK_BITS(64)) uut (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .rd_bank(rd_bank), .rd_idx(rd_idx), .rd_data(rd_data),
    .ack(ack), .ack_bank(ack_bank), .chunk_rdy(chunk_rdy),
    .chunk_bank(chunk_bank), .irq(irq), .bank_full(bank_full),
    .overrun(overrun), .fill_bank(fill_bank));

  always #2 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    ser_dat = b;
    repeat (4) @(negedge clk);
    ser_clk = 1'b1;
    repeat (4) @(negedge clk);
    ser_clk = 1'b0;
  endtask

  task automatic send_word(input logic [W-1:0] w);
    for (int i = W - 1; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic wait_rdy(input string req);
    bit seen = 0;
    for (int t = 0; t < 3000 && !seen; t++) begin
      @(negedge clk);
      if (chunk_rdy) seen = 1;
    end
    check(req, 64'(seen), 64'd1);
  endtask

  task automatic read_word(input logic b, input logic [1:0] i, output logic [W-1:0] d);
    rd_bank = b; rd_idx = i;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic do_ack(input logic b);
    ack_bank = b; ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [W-1:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 bank_full", 64'(bank_full), 64'd0);
    check("R1 overrun", 64'(overrun), 64'd0);
    check("R1 irq", 64'(irq), 64'd0);
    check("R1 chunk_rdy", 64'(chunk_rdy), 64'd0);
    check("R1 fill_bank", 64'(fill_bank), 64'd0);

    // vector table: continuous stream of four chunks, read while next fills
    fork
      begin
        for (int k = 0; k < 16; k++) send_word(VEC[k]);
      end
      begin
        for (int c = 0; c < 4; c++) begin
          wait_rdy("R3 chunk completes");
          check("R4 chunk_bank alternates", 64'(chunk_bank), 64'(c % 2));
          check("R5 bank_full set", 64'(bank_full[c % 2]), 64'd1);
          check("R6 irq high", 64'(irq), 64'd1);
          check("R4 fill_bank moved on", 64'(fill_bank), 64'((c + 1) % 2));
          @(negedge clk);
          check("R5 chunk_rdy one cycle", 64'(chunk_rdy), 64'd0);
          for (int i = 0; i < 4; i++) begin
            read_word(1'(c % 2), 2'(i), d);
            check("R2 R10 word data", 64'(d), 64'(VEC[c * 4 + i]));
          end
          do_ack(1'(c % 2));
          check("R7 ack clears bank", 64'(bank_full[c % 2]), 64'd0);
        end
      end
    join
    check("R6 irq low when empty", 64'(irq), 64'd0);
    check("R8 no overrun with timely ack", 64'(overrun), 64'd0);

    // R9 reset mid-word discards partial bits
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    do_reset();
    check("R9 fill_bank after reset", 64'(fill_bank), 64'd0);
    check("R1 bank_full after reset", 64'(bank_full), 64'd0);
    for (int k = 0; k < 4; k++) send_word(VEC[8 + k]);
    wait_rdy("R9 chunk after reset");
    check("R9 lands in bank 0", 64'(chunk_bank), 64'd0);
    read_word(1'b0, 2'd0, d);
    check("R9 word0 aligned", 64'(d), 64'(VEC[8]));
    read_word(1'b0, 2'd3, d);
    check("R9 word3 aligned", 64'(d), 64'(VEC[11]));

    // R8 overrun: three chunks without acknowledge
    do_reset();
    for (int k = 0; k < 12; k++) send_word(VEC[k]);
    repeat (20) @(negedge clk);
    check("R8 overrun set", 64'(overrun), 64'd1);
    check("R8 both banks full", 64'(bank_full), 64'd3);
    read_word(1'b0, 2'd0, d);
    check("R8 bank0 overwritten w0", 64'(d), 64'(VEC[8]));
    read_word(1'b0, 2'd3, d);
    check("R8 bank0 overwritten w3", 64'(d), 64'(VEC[11]));
    read_word(1'b1, 2'd2, d);
    check("R4 bank1 holds chunk1", 64'(d), 64'(VEC[6]));
    do_ack(1'b0);
    check("R7 ack bank0 only", 64'(bank_full), 64'd2);
    check("R6 irq still high", 64'(irq), 64'd1);
    do_ack(1'b1);
    check("R7 ack bank1", 64'(bank_full), 64'd0);
    check("R6 irq low", 64'(irq), 64'd0);
    check("R8 overrun sticky", 64'(overrun), 64'd1);
    do_reset();
    check("R1 overrun cleared by reset", 64'(overrun), 64'd0);

    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule